// File: doc/BRIEF.md
# Iterative Radix-4 Booth Multiplier

This block multiplies two signed two's-complement operands of `N` bits each (`N` even, default 6) and returns the full `2N`-bit signed product. It is sequential. A start strobe captures both operands. The block then retires two multiplier bits on each clock, so a product needs `N/2` accumulate steps.

In each step a three-bit window of the multiplier is recoded into a signed digit in the set {-2, -1, 0, +1, +2}. The window holds the bits y(2k+1), y(2k) and y(2k-1), and y(-1) is taken as zero. The digit picks zero, the multiplicand, or twice the multiplicand. That value is added to or subtracted from the accumulator. The multiplicand starts sign-extended to `2N` bits and is shifted left by two places after every step, so step k works at weight 4^k.

The accumulator drives the product output directly. This means the running partial sum can be watched step by step. The final value stays on the output until the next accepted start.

Top module: `booth_r4_mul`

## Requirements
- R1: While reset is asserted and after it is released, with no start seen, `product_o` is zero and `done_o` is low.
- R2: A start seen while the block is idle captures `x_i` and `y_i`. In the cycle after that edge, `product_o` reads zero and `done_o` is low.
- R3: Step k recodes the window {y(2k+1), y(2k), y(2k-1)}, with y(-1)=0, into an action. The codes map as follows:
  - 000 and 111: add nothing.
  - 001 and 010: add x.
  - 011: add 2x.
  - 100: subtract 2x.
  - 101 and 110: subtract x.
- R4: The multiplicand used in step k carries weight 4^k. After step k, `product_o` equals the sum of digit_j·x·4^j over j = 0..k, as a `2N`-bit two's-complement value.
- R5: `done_o` is high for exactly one cycle: the cycle after the `N/2`-th clock edge that follows the accepting edge.
- R6: When `done_o` is high, `product_o` equals the signed product x·y. This holds for every pair of signed `N`-bit operands, including the most negative values.
- R7: A start seen while a multiplication is in progress is ignored. The captured operands, the partial sums and the timing of `done_o` are unchanged.
- R8: After `done_o`, `product_o` holds the final product until the next accepted start.
- R9: With N=6, x=25 and y=-18, the partial sums after the three steps are -50, -50 and -450.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe; accepted only while idle |
| x_i | input | N | Signed multiplicand |
| y_i | input | N | Signed multiplier |
| product_o | output | 2N | Accumulator: running partial sum, then the final product |
| done_o | output | 1 | One-cycle pulse; product valid |

## Verification
The assertions rely on two things: reset is applied before the first start, and the operands only need to be valid at the edge that accepts a start. No other input protocol is needed.

Any level on `start_i` is legal at any time, so the stimulus may hold start high through a whole multiplication. The bench does this on purpose, driving different operands on later pairs to exercise R7.

All inputs change on the falling edge. Operands are swept over every signed 6-bit pair, so every recoding code appears in every step position.

// File: rtl/booth_r4_pkg.sv
package booth_r4_pkg;

  typedef enum logic [1:0] {
    MAG_ZERO = 2'd0,
    MAG_ONE  = 2'd1,
    MAG_TWO  = 2'd2
  } mag_e;

  typedef struct packed {
    logic neg;
    mag_e mag;
  } digit_t;

endpackage

// File: rtl/booth_r4_recode.sv
module booth_r4_recode
  import booth_r4_pkg::*;
(
  input  logic [2:0] win_i,
  output digit_t     dig_o
);

  always_comb begin
    unique case (win_i)
      3'b000:  dig_o = '{neg: 1'b0, mag: MAG_ZERO};
      3'b001:  dig_o = '{neg: 1'b0, mag: MAG_ONE};
      3'b010:  dig_o = '{neg: 1'b0, mag: MAG_ONE};
      3'b011:  dig_o = '{neg: 1'b0, mag: MAG_TWO};
      3'b100:  dig_o = '{neg: 1'b1, mag: MAG_TWO};
      3'b101:  dig_o = '{neg: 1'b1, mag: MAG_ONE};
      3'b110:  dig_o = '{neg: 1'b1, mag: MAG_ONE};
      default: dig_o = '{neg: 1'b0, mag: MAG_ZERO};
    endcase
  end

endmodule

// File: rtl/booth_r4_ctrl.sv
module booth_r4_ctrl #(
  parameter int unsigned STEPS = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic done_o
);

  localparam int unsigned CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS - 1);

  logic             busy_q;
  logic             done_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last;

  assign last   = (cnt_q == LAST);
  assign load_o = start_i & ~busy_q;
  assign step_o = busy_q;
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      done_q <= busy_q & last;
      if (load_o) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q) begin
        if (last) busy_q <= 1'b0;
        else      cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  // R5
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R5
  load_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> (busy_q && cnt_q == '0 && !done_o));

  // R7
  ignore_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i && !last) |=> (busy_q && cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/booth_r4_datapath.sv
module booth_r4_datapath
  import booth_r4_pkg::*;
#(
  parameter int unsigned N = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic            step_i,
  input  logic [N-1:0]    x_i,
  input  logic [N-1:0]    y_i,
  output logic [2*N-1:0]  acc_o
);

  localparam int unsigned PW = 2 * N;
  localparam int unsigned YW = N + 1;

  logic [PW-1:0] mcand_q;
  logic [YW-1:0] ybuf_q;
  logic [PW-1:0] acc_q;
  logic [PW-1:0] part;
  logic [PW-1:0] acc_nxt;
  digit_t        dig;

  booth_r4_recode i_recode (
    .win_i (ybuf_q[2:0]),
    .dig_o (dig)
  );

  always_comb begin
    unique case (dig.mag)
      MAG_ONE: part = mcand_q;
      MAG_TWO: part = {mcand_q[PW-2:0], 1'b0};
      default: part = '0;
    endcase
    acc_nxt = dig.neg ? (acc_q - part) : (acc_q + part);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcand_q <= '0;
      ybuf_q  <= '0;
      acc_q   <= '0;
    end else if (load_i) begin
      mcand_q <= {{N{x_i[N-1]}}, x_i};
      ybuf_q  <= {y_i, 1'b0};
      acc_q   <= '0;
    end else if (step_i) begin
      mcand_q <= {mcand_q[PW-3:0], 2'b00};
      ybuf_q  <= {{2{ybuf_q[YW-1]}}, ybuf_q[YW-1:2]};
      acc_q   <= acc_nxt;
    end
  end

  assign acc_o = acc_q;

  // R2
  load_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (acc_o == '0));

  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i) |=> $stable(acc_o));

  // R3
  zero_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dig.mag == MAG_ZERO && dig.neg));

  // R3
  idle_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && (ybuf_q[2:0] == 3'b000 || ybuf_q[2:0] == 3'b111))
      |=> $stable(acc_o));

endmodule

// File: rtl/booth_r4_mul.sv
module booth_r4_mul #(
  parameter int unsigned N = 6
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [N-1:0]   x_i,
  input  logic [N-1:0]   y_i,
  output logic [2*N-1:0] product_o,
  output logic           done_o
);

  localparam int unsigned STEPS = N / 2;

  logic load;
  logic step;

  booth_r4_ctrl #(.STEPS(STEPS)) i_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .load_o  (load),
    .step_o  (step),
    .done_o  (done_o)
  );

  booth_r4_datapath #(.N(N)) i_dp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .step_i (step),
    .x_i    (x_i),
    .y_i    (y_i),
    .acc_o  (product_o)
  );

endmodule

// File: tb/test_booth_r4_mul.sv
module test_booth_r4_mul;

  localparam int N     = 6;
  localparam int STEPS = N / 2;
  localparam int LO    = -(1 << (N - 1));
  localparam int HI    = (1 << (N - 1)) - 1;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           start_i = 1'b0;
  logic [N-1:0]   x_i = '0;
  logic [N-1:0]   y_i = '0;
  logic [2*N-1:0] product_o;
  logic           done_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk_i = ~clk_i;

  booth_r4_mul #(.N(N)) i_booth_r4_mul (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .x_i       (x_i),
    .y_i       (y_i),
    .product_o (product_o),
    .done_o    (done_o)
  );

  function automatic int prod_s();
    return int'($signed(product_o));
  endfunction

  function automatic int ybit(int y, int j);
    if (j < 0) return 0;
    return (y >>> j) & 1;
  endfunction

  task automatic chk_int(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Inputs change on the falling edge only.
  task automatic mult(int a, int b, bit poke);
    int acc;
    int w;
    acc = 0;
    @(negedge clk_i);
    start_i = 1'b1;
    x_i = N'(a);
    y_i = N'(b);
    @(negedge clk_i);
    if (poke) begin
      // R7: start held high with different operands while busy
      x_i = N'(~a);
      y_i = N'(b + 7);
    end else begin
      start_i = 1'b0;
    end
    chk_int("R2 product after start", prod_s(), 0);
    chk_int("R2 done after start", int'(done_o), 0);
    w = 1;
    for (int k = 0; k < STEPS; k++) begin
      int d;
      @(negedge clk_i);
      d = -2 * ybit(b, 2*k+1) + ybit(b, 2*k) + ybit(b, 2*k-1);
      acc = acc + d * a * w;
      w = w * 4;
      chk_int(poke ? "R7 R3 R4 partial" : "R3 R4 partial", prod_s(), acc);
      chk_int(poke ? "R7 R5 done" : "R5 done", int'(done_o), (k == STEPS-1) ? 1 : 0);
      if (k == STEPS-1) begin
        chk_int("R6 final product", prod_s(), a * b);
        start_i = 1'b0;
      end
    end
    @(negedge clk_i);
    chk_int("R5 done pulse width", int'(done_o), 0);
    chk_int("R8 product hold", prod_s(), a * b);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #5;
    chk_int("R1 product in reset", prod_s(), 0);
    chk_int("R1 done in reset", int'(done_o), 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk_int("R1 product after reset", prod_s(), 0);
    chk_int("R1 done after reset", int'(done_o), 0);

    // R9: worked example, partials -50, -50, -450
    @(negedge clk_i);
    start_i = 1'b1;
    x_i = N'(25);
    y_i = N'(-18);
    @(negedge clk_i);
    start_i = 1'b0;
    @(negedge clk_i);
    chk_int("R9 step 1", prod_s(), -50);
    @(negedge clk_i);
    chk_int("R9 step 2", prod_s(), -50);
    @(negedge clk_i);
    chk_int("R9 step 3", prod_s(), -450);
    chk_int("R9 done", int'(done_o), 1);
    repeat (3) @(negedge clk_i);
    chk_int("R8 idle hold", prod_s(), -450);

    // R7: start held through busy cycles
    mult(25, -18, 1'b1);
    mult(LO, LO, 1'b1);
    mult(HI, -1, 1'b1);

    // R6: exhaustive signed sweep
    for (int a = LO; a <= HI; a++) begin
      for (int b = LO; b <= HI; b++) begin
        mult(a, b, 1'b0);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule